// File: doc/BRIEF.md
# Configuration Store Access Guard

This block sits in front of the connection store of a programmable logic array. It takes one command at a time over a valid/ready handshake. A command can wipe the whole store, set connection bits in one word, read one word back, lock the store, write one slice of a 64-bit identification word, or read that slice back. Every command ends with a response pulse that carries either read data or an error flag.

A word is programmed by setting bits only: a 1 in the write data turns the matching connection on, and a 0 leaves the bit as it was. A connection can be turned off only by a wipe, which clears every word, the identification word and the lock. The wipe runs for one cycle per stored word, and the block stays busy for that whole time. Once the lock is set, every command that reads or programs the store or the identification word is refused. The wipe is the only way to clear the lock.

The lock also comes up set out of reset, because the store content is undefined until the first wipe. The store is a plain synchronous RAM with no reset. The lock, the identification word and the control state are flops.

Top module: `cfgmem_guard`

## Requirements
- R1: After reset, `cmd_ready` is 1, `busy` is 0, `locked` is 1 and no response is pending.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. Any opcode except wipe then keeps `busy` high for exactly one cycle. It is answered by a `rsp_valid` pulse one cycle wide in the following cycle, and `cmd_ready` equals the inverse of `busy`.
- R3: The wipe command (opcode 1) keeps `busy` high for exactly 2^ADDR_W cycles and then pulses `rsp_valid` without error. After the wipe, every word reads 0, every identification slice reads 0 and `locked` is 0. `locked` never falls at any other time.
- R4: The program command (opcode 2) makes the word at `cmd_addr` equal to its old value OR `cmd_wdata`. Bits already at 1 stay at 1.
- R5: The read command (opcode 3) returns the word at `cmd_addr` on `rsp_rdata` in the response cycle.
- R6: The seal command (opcode 4) sets `locked` in the response cycle. A program command with `cmd_seal` at 1 writes the word and also sets `locked` in its response cycle.
- R7: While `locked` is 1, the program (2), read (3), identification-write (5) and identification-read (6) commands are refused. A refusal sets `rsp_err` with `rsp_rdata` at 0, and `locked` stays 1.
- R8: Identification-write (opcode 5) stores `cmd_wdata` into the slice of the 64-bit word that is selected by the low log2(64/DATA_W) bits of `cmd_addr`. Identification-read (opcode 6) returns the slice selected the same way, and the other slices stay unchanged.
- R9: Opcodes 0 and 7 are always refused with `rsp_err` and do not change `locked`.
- R10: `rsp_err` is 1 only together with `rsp_valid`. `rsp_rdata` is 0 in every cycle except the response cycle of an accepted read of either kind.
- R11: A command presented during a wipe is held off while `cmd_ready` is 0. It is taken on the first edge after the wipe response and then served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is presented |
| cmd_ready | output | 1 | The block can take a command this cycle |
| cmd_op | input | 3 | Opcode: 1 wipe, 2 program, 3 read, 4 seal, 5 identification write, 6 identification read |
| cmd_addr | input | ADDR_W | Word address, or slice index in its low bits |
| cmd_wdata | input | DATA_W | Bits to set, or slice value |
| cmd_seal | input | 1 | Sets the lock after a program command |
| busy | output | 1 | A command is being executed |
| locked | output | 1 | The lock is set |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | The completed command was refused |
| rsp_rdata | output | DATA_W | Read data, otherwise 0 |

## Verification
The bench builds the block with ADDR_W=4 and DATA_W=16. A wipe then lasts 16 cycles, so its full length and a command waiting behind it fit in a short run. The 64-bit identification word splits into four slices, so slice selection through the low address bits is exercised with an index above 1 and with addresses that alias to the same slice. A behavioural model runs in lockstep and compares every output on every clock, while directed cases check OR accumulation, refusals under the lock and the unlock by wipe.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WIPE  = 3'd1,
    OP_PROG  = 3'd2,
    OP_READ  = 3'd3,
    OP_SEAL  = 3'd4,
    OP_IDWR  = 3'd5,
    OP_IDRD  = 3'd6,
    OP_RSVD  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_WIPE = 2'd2
  } st_e;

  localparam int ID_BITS = 64;

  // commands that touch protected content
  function automatic logic op_guarded(op_e op);
    return (op == OP_PROG) || (op == OP_READ) || (op == OP_IDWR) || (op == OP_IDRD);
  endfunction

  function automatic logic op_known(op_e op);
    return (op != OP_NONE) && (op != OP_RSVD);
  endfunction

endpackage

// File: rtl/cfgmem_array.sv
module cfgmem_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // single read port, single write port, no reset: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
    if (re) rdata <= mem_q[raddr];
  end

endmodule

// File: rtl/cfgmem_ident.sv
module cfgmem_ident
  import cfgmem_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SLICES = ID_BITS / DATA_W,
  localparam int SEL_W  = (SLICES > 1) ? $clog2(SLICES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] slice_q [SLICES];

  for (genvar g = 0; g < SLICES; g++) begin : g_slice
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        slice_q[g] <= '0;
      end else if (we && (sel == SEL_W'(g))) begin
        slice_q[g] <= wdata;
      end
    end
  end

  assign rdata = slice_q[sel];

endmodule

// File: rtl/cfgmem_seq.sv
module cfgmem_seq
  import cfgmem_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_seal,
  output logic              busy,
  output logic              locked,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              arr_re,
  output logic [ADDR_W-1:0] arr_raddr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              id_clr,
  output logic              id_we,
  output logic [SEL_W-1:0]  id_sel,
  output logic [DATA_W-1:0] id_wdata,
  input  logic [DATA_W-1:0] id_rdata
);
  st_e               st_q;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              seal_q;
  logic [ADDR_W-1:0] sweep_q;
  logic              lock_q;
  logic              rv_q, re_q;
  logic [DATA_W-1:0] rd_q;

  logic accept, refuse, run_ok, sweep_last;

  assign accept     = cmd_valid && (st_q == ST_IDLE);
  assign refuse     = !op_known(op_q) || (lock_q && op_guarded(op_q));
  assign run_ok     = (st_q == ST_EXEC) && !refuse;
  assign sweep_last = (st_q == ST_WIPE) && (&sweep_q);

  // the read is issued at acceptance so the old word is ready for OR-merge
  assign arr_re    = accept;
  assign arr_raddr = cmd_addr;
  assign arr_we    = (st_q == ST_WIPE) || (run_ok && (op_q == OP_PROG));
  assign arr_waddr = (st_q == ST_WIPE) ? sweep_q : addr_q;
  assign arr_wdata = (st_q == ST_WIPE) ? '0 : (arr_rdata | wdata_q);

  assign id_clr   = sweep_last;
  assign id_we    = run_ok && (op_q == OP_IDWR);
  assign id_sel   = addr_q[SEL_W-1:0];
  assign id_wdata = wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_NONE;
      addr_q  <= '0;
      wdata_q <= '0;
      seal_q  <= 1'b0;
      sweep_q <= '0;
      lock_q  <= 1'b1;
      rv_q    <= 1'b0;
      re_q    <= 1'b0;
      rd_q    <= '0;
    end else begin
      rv_q <= 1'b0;
      re_q <= 1'b0;
      rd_q <= '0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            op_q    <= op_e'(cmd_op);
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
            seal_q  <= cmd_seal;
            sweep_q <= '0;
            st_q    <= (op_e'(cmd_op) == OP_WIPE) ? ST_WIPE : ST_EXEC;
          end
        end
        ST_EXEC: begin
          st_q <= ST_IDLE;
          rv_q <= 1'b1;
          re_q <= refuse;
          if (!refuse) begin
            case (op_q)
              OP_READ: rd_q   <= arr_rdata;
              OP_IDRD: rd_q   <= id_rdata;
              OP_SEAL: lock_q <= 1'b1;
              OP_PROG: if (seal_q) lock_q <= 1'b1;
              default: ;
            endcase
          end
        end
        ST_WIPE: begin
          sweep_q <= sweep_q + 1'b1;
          if (sweep_last) begin
            st_q   <= ST_IDLE;
            lock_q <= 1'b0;
            rv_q   <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign locked    = lock_q;
  assign rsp_valid = rv_q;
  assign rsp_err   = re_q;
  assign rsp_rdata = rd_q;

endmodule

// File: rtl/cfgmem_guard.sv
module cfgmem_guard
  import cfgmem_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_seal,
  output logic              busy,
  output logic              locked,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int SLICES = ID_BITS / DATA_W;
  localparam int SEL_W  = (SLICES > 1) ? $clog2(SLICES) : 1;

  logic              arr_re, arr_we, id_clr, id_we;
  logic [ADDR_W-1:0] arr_raddr, arr_waddr;
  logic [DATA_W-1:0] arr_rdata, arr_wdata, id_wdata, id_rdata;
  logic [SEL_W-1:0]  id_sel;

  cfgmem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) seq_i (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_seal(cmd_seal),
    .busy(busy), .locked(locked),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .arr_re(arr_re), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata),
    .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
    .id_clr(id_clr), .id_we(id_we), .id_sel(id_sel),
    .id_wdata(id_wdata), .id_rdata(id_rdata)
  );

  cfgmem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
    .clk(clk), .re(arr_re), .raddr(arr_raddr), .rdata(arr_rdata),
    .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata)
  );

  cfgmem_ident #(.DATA_W(DATA_W)) ident_i (
    .clk(clk), .rst(rst), .clr(id_clr), .we(id_we), .sel(id_sel),
    .wdata(id_wdata), .rdata(id_rdata)
  );

endmodule

// File: rtl/cfgmem_guard_chk.sv
module cfgmem_guard_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic              busy,
  input logic              locked,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [2:0] last_op;
  int         run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_op <= 3'd0;
      run_len <= 0;
    end else if (cmd_valid && cmd_ready) begin
      last_op <= cmd_op;
      run_len <= 0;
    end else if (busy) begin
      run_len <= run_len + 1;
    end
  end

  logic guarded_op;
  assign guarded_op = (last_op == 3'd2) || (last_op == 3'd3) || (last_op == 3'd5) || (last_op == 3'd6);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (locked && cmd_ready && !busy && !rsp_valid));

  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_exec_len_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && last_op != 3'd1) |-> (run_len == 1));

  assert_wipe_len_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && last_op == 3'd1) |-> (run_len == DEPTH && !rsp_err));

  assert_unlock_by_wipe_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> (rsp_valid && last_op == 3'd1));

  assert_refuse_locked_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(locked) && guarded_op) |-> (rsp_err && rsp_rdata == '0));

  assert_refuse_unknown_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (last_op == 3'd0 || last_op == 3'd7)) |-> rsp_err);

  assert_err_in_rsp_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_valid);

  assert_quiet_data_R10: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (rsp_rdata == '0));

endmodule

bind cfgmem_guard cfgmem_guard_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .busy(busy), .locked(locked), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
);

// File: tb/cfgmem_guard_tb_top.sv
module cfgmem_guard_tb_top;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam int NSL = 64 / DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          cmd_seal = 1'b0;
  logic          cmd_ready, busy, locked, rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  cfgmem_guard #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_seal(cmd_seal), .busy(busy), .locked(locked),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int            m_left = 0;
  int            m_op, m_addr;
  logic [DW-1:0] m_wd;
  logic          m_seal;
  logic          m_locked = 1'b1;
  logic [DW-1:0] m_mem [DEPTH];
  logic [DW-1:0] m_id  [NSL];
  logic          m_rv = 1'b0, m_re = 1'b0;
  logic [DW-1:0] m_rd = '0;

  task automatic model_finish();
    bit no;
    no = (m_op == 0) || (m_op == 7) ||
         (m_locked && (m_op == 2 || m_op == 3 || m_op == 5 || m_op == 6));
    m_rv = 1'b1;
    if (no) begin
      m_re = 1'b1;
    end else begin
      case (m_op)
        1: begin
          for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
          for (int i = 0; i < NSL; i++) m_id[i] = '0;
          m_locked = 1'b0;
        end
        2: begin
          m_mem[m_addr] = m_mem[m_addr] | m_wd;
          if (m_seal) m_locked = 1'b1;
        end
        3: m_rd = m_mem[m_addr];
        4: m_locked = 1'b1;
        5: m_id[m_addr % NSL] = m_wd;
        6: m_rd = m_id[m_addr % NSL];
        default: ;
      endcase
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_left = 0; m_locked = 1'b1; m_rv = 1'b0; m_re = 1'b0; m_rd = '0;
      for (int i = 0; i < NSL; i++) m_id[i] = '0;
    end else begin
      m_rv = 1'b0; m_re = 1'b0; m_rd = '0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) model_finish();
      end else if (cmd_valid) begin
        m_op = int'(cmd_op); m_addr = int'(cmd_addr);
        m_wd = cmd_wdata; m_seal = cmd_seal;
        m_left = (cmd_op == 3'd1) ? DEPTH : 1;
      end
    end
  end

  // lockstep comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 ready", 32'(cmd_ready), 32'(m_left == 0));
      chk("R2 busy", 32'(busy), 32'(m_left != 0));
      chk("R6 locked", 32'(locked), 32'(m_locked));
      chk("R2 rsp_valid", 32'(rsp_valid), 32'(m_rv));
      chk("R7 rsp_err", 32'(rsp_err), 32'(m_re));
      chk("R5 rsp_rdata", 32'(rsp_rdata), 32'(m_rd));
    end
  end

  logic [DW-1:0] got_rd;
  logic          got_err;
  int            got_busy;

  task automatic issue(input int op, input int addr, input logic [DW-1:0] wd, input logic seal);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = AW'(addr);
    cmd_wdata = wd; cmd_seal = seal;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_seal = 1'b0;
    got_busy = 0;
    while (!rsp_valid) begin
      if (busy) got_busy++;
      @(negedge clk);
    end
    got_rd = rsp_rdata;
    got_err = rsp_err;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready", 32'(cmd_ready), 32'd1);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 locked", 32'(locked), 32'd1);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);

    issue(3, 2, '0, 1'b0);
    chk("R7 read refused err", 32'(got_err), 32'd1);
    chk("R7 read refused data", 32'(got_rd), 32'd0);
    issue(6, 1, '0, 1'b0);
    chk("R7 id read refused", 32'(got_err), 32'd1);

    issue(1, 0, '0, 1'b0);
    chk("R3 wipe busy length", 32'(got_busy), 32'(DEPTH));
    chk("R3 wipe no err", 32'(got_err), 32'd0);
    @(negedge clk);
    chk("R3 unlocked", 32'(locked), 32'd0);
    issue(3, 3, '0, 1'b0);
    chk("R3 wiped word", 32'(got_rd), 32'h0);

    issue(2, 3, 16'h00F0, 1'b0);
    chk("R2 exec busy", 32'(got_busy), 32'd1);
    issue(2, 3, 16'h0F01, 1'b0);
    issue(3, 3, '0, 1'b0);
    chk("R4 or-merge", 32'(got_rd), 32'h0FF1);
    issue(2, 3, 16'h0000, 1'b0);
    issue(3, 3, '0, 1'b0);
    chk("R4 zero keeps bits", 32'(got_rd), 32'h0FF1);
    issue(2, 9, 16'hA5A5, 1'b0);
    issue(3, 9, '0, 1'b0);
    chk("R5 read word 9", 32'(got_rd), 32'hA5A5);

    issue(5, 0, 16'h1234, 1'b0);
    issue(5, 2, 16'hBEEF, 1'b0);
    issue(6, 2, '0, 1'b0);
    chk("R8 slice 2", 32'(got_rd), 32'hBEEF);
    issue(6, 0, '0, 1'b0);
    chk("R8 slice 0", 32'(got_rd), 32'h1234);
    issue(6, 1, '0, 1'b0);
    chk("R8 slice 1 untouched", 32'(got_rd), 32'h0);
    issue(6, 6, '0, 1'b0);
    chk("R8 address alias", 32'(got_rd), 32'hBEEF);

    issue(0, 0, '0, 1'b0);
    chk("R9 op0 err", 32'(got_err), 32'd1);
    issue(7, 0, '0, 1'b0);
    chk("R9 op7 err", 32'(got_err), 32'd1);
    chk("R9 lock unchanged", 32'(locked), 32'd0);

    issue(4, 0, '0, 1'b0);
    chk("R6 seal", 32'(locked), 32'd1);
    issue(3, 3, '0, 1'b0);
    chk("R7 locked read err", 32'(got_err), 32'd1);
    chk("R10 refused data zero", 32'(got_rd), 32'd0);
    issue(2, 3, 16'hFFFF, 1'b0);
    chk("R7 locked prog err", 32'(got_err), 32'd1);
    issue(5, 1, 16'h7777, 1'b0);
    chk("R7 locked id write err", 32'(got_err), 32'd1);
    chk("R7 still locked", 32'(locked), 32'd1);

    issue(1, 0, '0, 1'b0);
    issue(3, 3, '0, 1'b0);
    chk("R3 word cleared", 32'(got_rd), 32'h0);
    issue(6, 2, '0, 1'b0);
    chk("R3 id cleared", 32'(got_rd), 32'h0);

    issue(2, 5, 16'h00FF, 1'b1);
    chk("R6 prog with seal", 32'(locked), 32'd1);

    // R11: a read waits behind a wipe
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_addr = '0;
    @(negedge clk);
    cmd_op = 3'd3; cmd_addr = AW'(5);
    begin
      int waited = 0;
      while (!cmd_ready) begin waited++; @(negedge clk); end
      chk("R11 held during wipe", 32'(waited), 32'(DEPTH));
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk("R11 queued read err", 32'(rsp_err), 32'd0);
    chk("R11 queued read data", 32'(rsp_rdata), 32'h0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule